// File: doc/BRIEF.md
# Oversampling Serial Receiver with Line Error Detection

This block turns an asynchronous serial input into bytes for a receive FIFO. The line passes through a two-stage synchroniser. A tick generator, set by a 16-bit divisor, runs the sampling at sixteen times the bit rate. A receive state machine then finds the start bit, rejects glitches, shifts in data least significant bit first, checks an optional parity bit and checks the stop bit.

A received character is 7 or 8 data bits long. A 7-bit character is padded with a zero in bit 7. The parity check is odd, even or off. The character length and the parity mode are inputs that software drives. They are captured when a start edge is seen, so they hold for the whole frame. Each finished character goes out as a one-cycle write pulse with its data. Parity, framing, break and overrun problems go out as one-cycle pulses, and a status block elsewhere latches them.

The state machine has six states:
- `ST_IDLE` waits for the line to go low.
- `ST_START` checks the middle of the start bit. If the line is high there, it returns to `ST_IDLE` (glitch). If it is low, it moves to `ST_DATA`.
- `ST_DATA` collects the data bits. After the last one it moves to `ST_PARITY` when parity is on, otherwise to `ST_STOP`.
- `ST_PARITY` samples the parity bit and moves to `ST_STOP`.
- `ST_STOP` samples the stop bit. It returns to `ST_IDLE` if the stop bit is high, or moves to `ST_RECOVER` if it is low.
- `ST_RECOVER` waits for the line to go high and then returns to `ST_IDLE`.

Top module: `serial_rx_engine`

## Requirements
- R1: A sampling tick occurs once every `divisor` clock cycles, and every cycle when `divisor` is 0 or 1. One bit lasts 16 ticks, and each bit is sampled at its middle (tick 8 after the start edge, then every 16 ticks).
- R2: A low pulse on `rx_in` that has ended before the middle of the start bit is ignored. It produces no write and no error pulse.
- R3: With `short_char`=0, eight data bits are received least significant bit first. They are presented on `wr_data` together with a `wr_en` pulse exactly one cycle wide.
- R4: With `short_char`=1, seven data bits are received and written with `wr_data[7]`=0.
- R5: `parity_mode` encodes 0 as none, 1 as odd and 2 as even. The value 3 is treated as none. When parity is on, one parity bit follows the data. `err_parity` pulses when the total number of ones over data plus parity does not match the selected mode.
- R6: A stop bit sampled as 0 pulses `err_frame`. The character is still written if the FIFO has room.
- R7: `err_break` pulses, together with `err_frame`, when every data bit and the stop bit were 0. In that case the written data is 0.
- R8: If `fifo_full` is high when a character completes, `err_overrun` pulses, no `wr_en` is given and the character is lost.
- R9: Changing `short_char` or `parity_mode` after a start edge has no effect on the frame in progress.
- R10: After a stop bit sampled as 0, no new frame begins until the line has gone high. A line held low therefore reports exactly one break.
- R11: During and right after reset, `wr_en` and all error pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Asynchronous serial line, high when idle |
| divisor | input | 16 | Clock cycles per sampling tick |
| short_char | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| parity_mode | input | 2 | 0 none, 1 odd, 2 even, 3 treated as none |
| fifo_full | input | 1 | Receive FIFO cannot take a write |
| wr_en | output | 1 | One-cycle FIFO write pulse |
| wr_data | output | 8 | Received character |
| err_parity | output | 1 | One-cycle parity mismatch pulse |
| err_frame | output | 1 | One-cycle stop-bit-low pulse |
| err_break | output | 1 | One-cycle all-zero frame pulse |
| err_overrun | output | 1 | One-cycle character-dropped pulse |

## Verification
The main receive path is tried with these patterns:
- Alternating and asymmetric bytes such as 0xA5, 0x5A and 0x96 show that bit order and bit count are right.
- 7-bit frames sent from bytes with bit 7 set show that bit 7 is padded rather than picked up from the stop bit.
- Frames with a correct and with an inverted parity bit, in both odd and even mode and with the reserved code, separate the parity polarity from the bit count.
- A zero stop bit on a non-zero byte separates framing from break.
- An all-zero frame followed by a long low line shows that only one break is reported.
- A short low glitch, a mid-frame change of configuration and two other divisor values test start qualification, the capture of the configuration and the tick rate.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_RECOVER
    } srx_state_t;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_ODD  = 2'd1,
        PAR_EVEN = 2'd2,
        PAR_RSVD = 2'd3
    } srx_parity_t;

    function automatic logic parity_on(input logic [1:0] mode);
        return (mode == PAR_ODD) || (mode == PAR_EVEN);
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/srx_tick.sv
module srx_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    logic [DIV_W-1:0] count;
    logic             wrap;

    always_comb begin
        if (divisor <= DIV_W'(1)) begin
            wrap = 1'b1;
        end else begin
            wrap = (count >= divisor - DIV_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            tick  <= 1'b0;
        end else begin
            tick  <= wrap;
            count <= wrap ? '0 : count + DIV_W'(1);
        end
    end

endmodule

// File: rtl/srx_fsm.sv
module srx_fsm
    import srx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_s,
    input  logic              cfg_short,
    input  logic [1:0]        cfg_parity,
    input  logic              fifo_full,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_break,
    output logic              err_overrun
);

    localparam int SUB_W = $clog2(OVERSAMPLE);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVERSAMPLE / 2 - 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

    srx_state_t        state, state_nx;
    logic [SUB_W-1:0]  sub;
    logic [CNT_W-1:0]  bitcnt;
    logic [CNT_W-1:0]  last_bit;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              lat_short;
    logic [1:0]        lat_parity;
    logic              bit_end;
    logic              stop_sample;
    logic [DATA_W-1:0] char_val;
    logic              par_expect;

    assign bit_end     = tick && (sub == SUB_LAST);
    assign last_bit    = lat_short ? CNT_W'(DATA_W - 2) : CNT_W'(DATA_W - 1);
    assign stop_sample = (state == ST_STOP) && bit_end;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!rx_s) state_nx = ST_START;
            end
            ST_START: begin
                if (tick && sub == SUB_MID) begin
                    state_nx = rx_s ? ST_IDLE : ST_DATA;
                end
            end
            ST_DATA: begin
                if (bit_end && bitcnt == last_bit) begin
                    state_nx = parity_on(lat_parity) ? ST_PARITY : ST_STOP;
                end
            end
            ST_PARITY: begin
                if (bit_end) state_nx = ST_STOP;
            end
            ST_STOP: begin
                if (bit_end) state_nx = rx_s ? ST_IDLE : ST_RECOVER;
            end
            ST_RECOVER: begin
                if (rx_s) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // frame datapath: tick phase, bit counter, shifter, captured config
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub        <= '0;
            bitcnt     <= '0;
            shreg      <= '0;
            par_bit    <= 1'b0;
            lat_short  <= 1'b0;
            lat_parity <= PAR_NONE;
        end else begin
            if (state_nx != state || state == ST_IDLE) begin
                sub <= '0;
            end else if (tick) begin
                sub <= (sub == SUB_LAST) ? '0 : sub + SUB_W'(1);
            end

            if (state == ST_IDLE) begin
                bitcnt <= '0;
                if (!rx_s) begin
                    lat_short  <= cfg_short;
                    lat_parity <= cfg_parity;
                end
            end

            if (state == ST_DATA && bit_end) begin
                shreg  <= {rx_s, shreg[DATA_W-1:1]};
                bitcnt <= bitcnt + CNT_W'(1);
            end

            if (state == ST_PARITY && bit_end) begin
                par_bit <= rx_s;
            end
        end
    end

    assign char_val   = lat_short ? {1'b0, shreg[DATA_W-1:1]} : shreg;
    assign par_expect = (lat_parity == PAR_ODD) ? ~(^char_val) : (^char_val);

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en       <= 1'b0;
            wr_data     <= '0;
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_break   <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            wr_en       <= 1'b0;
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_break   <= 1'b0;
            err_overrun <= 1'b0;
            if (stop_sample) begin
                err_parity <= parity_on(lat_parity) && (par_bit != par_expect);
                err_frame  <= !rx_s;
                err_break  <= !rx_s && (char_val == '0);
                if (fifo_full) begin
                    err_overrun <= 1'b1;
                end else begin
                    wr_en   <= 1'b1;
                    wr_data <= char_val;
                end
            end
        end
    end

endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine #(
    parameter int DIV_W       = 16,
    parameter int DATA_W      = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              short_char,
    input  logic [1:0]        parity_mode,
    input  logic              fifo_full,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_break,
    output logic              err_overrun
);

    logic rx_s;
    logic tick;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rx_in),
        .sync_out (rx_s)
    );

    srx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .tick    (tick)
    );

    srx_fsm #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .rx_s        (rx_s),
        .cfg_short   (short_char),
        .cfg_parity  (parity_mode),
        .fifo_full   (fifo_full),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .err_parity  (err_parity),
        .err_frame   (err_frame),
        .err_break   (err_break),
        .err_overrun (err_overrun)
    );

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_full,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              err_parity,
    input logic              err_frame,
    input logic              err_break,
    input logic              err_overrun
);

    AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R3

    AST_OVR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |-> !wr_en); // R8

    AST_OVR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |-> $past(fifo_full)); // R8

    AST_WR_WHEN_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(fifo_full)); // R8

    AST_BREAK_HAS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        err_break |-> err_frame); // R7

    AST_BREAK_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (err_break && wr_en) |-> (wr_data == '0)); // R7

    AST_ERR_WITH_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        (err_parity || err_frame) |-> (wr_en || err_overrun)); // R6

    AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_frame |=> !err_frame); // R10

endmodule

bind serial_rx_engine srx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_full   (fifo_full),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .err_break   (err_break),
    .err_overrun (err_overrun)
);

// File: tb/sim_serial_rx_engine.sv
`timescale 1ns/1ps
module sim_serial_rx_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_in = 1'b1;
    logic [15:0] divisor = 16'd2;
    logic        short_char = 1'b0;
    logic [1:0]  parity_mode = 2'd0;
    logic        fifo_full = 1'b0;
    logic        wr_en;
    logic [7:0]  wr_data;
    logic        err_parity, err_frame, err_break, err_overrun;

    int n_checks = 0;
    int n_fail   = 0;
    int c_wr = 0, c_par = 0, c_frm = 0, c_brk = 0, c_ovr = 0;
    logic [7:0] last_data = 8'h00;

    always #2.5 clk = ~clk;

    serial_rx_engine u0 (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .divisor(divisor),
        .short_char(short_char), .parity_mode(parity_mode), .fifo_full(fifo_full),
        .wr_en(wr_en), .wr_data(wr_data), .err_parity(err_parity),
        .err_frame(err_frame), .err_break(err_break), .err_overrun(err_overrun)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                c_wr <= c_wr + 1;
                last_data <= wr_data;
            end
            if (err_parity)  c_par <= c_par + 1;
            if (err_frame)   c_frm <= c_frm + 1;
            if (err_break)   c_brk <= c_brk + 1;
            if (err_overrun) c_ovr <= c_ovr + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v, input int div);
        rx_in = v;
        repeat (16 * ((div < 1) ? 1 : div)) @(negedge clk);
    endtask

    // Drive one frame: start, data LSB first, optional parity, stop, two idle bits.
    task automatic send(input logic [7:0] d, input logic short7, input logic [1:0] par,
                        input logic stopv, input logic flip, input int div);
        int   nb = short7 ? 7 : 8;
        logic p;
        logic [7:0] m = short7 ? {1'b0, d[6:0]} : d;
        p = (par == 2'd1) ? ~(^m) : (^m);
        hold_bit(1'b0, div);
        for (int i = 0; i < nb; i++) hold_bit(m[i], div);
        if (par == 2'd1 || par == 2'd2) hold_bit(p ^ flip, div);
        hold_bit(stopv, div);
        hold_bit(1'b1, div);
        hold_bit(1'b1, div);
    endtask

    // {data[7:0], short, parity[1:0], stop, flip, full}
    localparam int NV = 11;
    localparam logic [13:0] VEC [NV] = '{
        {8'hA5, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0},
        {8'h3C, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0},
        {8'h5A, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0},
        {8'h5A, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0},
        {8'h81, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0},
        {8'h7F, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0},
        {8'hC3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},
        {8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},
        {8'h96, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1},
        {8'h4B, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0},
        {8'hFF, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0}
    };

    task automatic final_report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        final_report();
    end

    initial begin
        int w0, p0, f0, b0, o0;
        repeat (4) @(negedge clk);
        // R11: outputs quiet during reset
        chk("R11 wr_en in reset", wr_en, 0);
        chk("R11 errors in reset", {err_parity, err_frame, err_break, err_overrun}, 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk("R11 wr after reset", c_wr, 0);
        chk("R11 errs after reset", c_par + c_frm + c_brk + c_ovr, 0);

        for (int k = 0; k < NV; k++) begin
            logic [7:0] d   = VEC[k][13:6];
            logic       s7  = VEC[k][5];
            logic [1:0] pm  = VEC[k][4:3];
            logic       sv  = VEC[k][2];
            logic       fl  = VEC[k][1];
            logic       fu  = VEC[k][0];
            logic [7:0] m   = s7 ? {1'b0, d[6:0]} : d;
            logic       pen = (pm == 2'd1) || (pm == 2'd2);
            short_char  = s7;
            parity_mode = pm;
            fifo_full   = fu;
            w0 = c_wr; p0 = c_par; f0 = c_frm; b0 = c_brk; o0 = c_ovr;
            send(d, s7, pm, sv, fl, 2);
            chk("R8 write count", c_wr - w0, fu ? 0 : 1);
            if (!fu) chk(s7 ? "R4 short data" : "R3 data", last_data, m);
            chk("R5 parity error", c_par - p0, (pen && fl) ? 1 : 0);
            chk("R6 frame error", c_frm - f0, sv ? 0 : 1);
            chk("R7 break error", c_brk - b0, (!sv && m == 8'h00) ? 1 : 0);
            chk("R8 overrun", c_ovr - o0, fu ? 1 : 0);
        end
        fifo_full = 1'b0;
        short_char = 1'b0;
        parity_mode = 2'd0;

        // R2: short low glitch is ignored
        w0 = c_wr; f0 = c_frm;
        rx_in = 1'b0;
        repeat (6) @(negedge clk);
        rx_in = 1'b1;
        repeat (16 * 2 * 12) @(negedge clk);
        chk("R2 glitch write", c_wr - w0, 0);
        chk("R2 glitch error", c_frm - f0, 0);

        // R10: break then line held low -> single break
        w0 = c_wr; b0 = c_brk;
        for (int i = 0; i < 10; i++) hold_bit(1'b0, 2);
        for (int i = 0; i < 40; i++) hold_bit(1'b0, 2);
        hold_bit(1'b1, 2);
        hold_bit(1'b1, 2);
        chk("R10 single break", c_brk - b0, 1);
        chk("R10 single write", c_wr - w0, 1);
        send(8'h69, 1'b0, 2'd0, 1'b1, 1'b0, 2);
        chk("R10 resumes", last_data, 8'h69);

        // R9: configuration change mid-frame has no effect
        w0 = c_wr; p0 = c_par;
        fork
            send(8'hB7, 1'b0, 2'd0, 1'b1, 1'b0, 2);
            begin
                repeat (16 * 2 * 3) @(negedge clk);
                short_char = 1'b1;
                parity_mode = 2'd2;
            end
        join
        chk("R9 write", c_wr - w0, 1);
        chk("R9 data 8-bit kept", last_data, 8'hB7);
        chk("R9 no parity error", c_par - p0, 0);
        short_char = 1'b0;
        parity_mode = 2'd0;

        // R1: other divisor values
        divisor = 16'd5;
        repeat (100) @(negedge clk);
        send(8'hD2, 1'b0, 2'd1, 1'b1, 1'b0, 5);
        chk("R1 divisor 5 data", last_data, 8'hD2);
        divisor = 16'd1;
        repeat (100) @(negedge clk);
        w0 = c_wr;
        send(8'h1E, 1'b0, 2'd0, 1'b1, 1'b0, 1);
        chk("R1 divisor 1 write", c_wr - w0, 1);
        chk("R1 divisor 1 data", last_data, 8'h1E);

        final_report();
    end

endmodule